// File: doc/BRIEF.md
# Card Clock Divider with Stop/Start Gating

This block derives the clock enable for a memory-card bus from the fixed system clock. Software picks a rate with a small log2 code and then starts or stops the card clock through a command strobe. Codes below the top value divide the system clock by a power of two, from 1 up to 64. The top code hands the output over to a separate fast tick input, which comes from a fixed high-speed source. The output `cardEn` is high for one system-clock cycle per card-clock period. Downstream shifters use it as their clock enable.

A rate code can be written at any time, but it is only copied into the running divider when a start command arrives. A stop is a request: the card clock keeps running until the end of its current period, so no short period is ever produced. The `clkRunning` status stays high until that moment. Software polls it before touching other configuration. On the cycle the gate closes, a one-cycle `clkOffEvt` pulse marks the running-to-stopped transition.

Top module: `card_clk_gen`

## Requirements
- R1: After reset `clkRunning`, `cardEn` and `clkOffEvt` are low and the stored rate code is 0. A start without any rate write then gives `cardEn` high in every cycle.
- R2: Rate codes c = 0..6 give one `cardEn` pulse every 2^c cycles. Count the first cycle after the start-command clock edge as cycle 0; pulses then fall in cycles k where (k+1) mod 2^c = 0.
- R3: With rate code 7 and the clock running, `cardEn` follows the `fastTick` input in the same cycle.
- R4: A rate write (`rateWrite` high, value on `rateCode`) does not change the period of a clock that is already running.
- R5: A write with `ctlCmd` bit 1 set (2'b10 or 2'b11) is a start. `clkRunning` is high from the next cycle, using the last rate code written, including one written in the same cycle.
- R6: A write with `ctlCmd` = 2'b01 is a stop. The clock keeps producing `cardEn` pulses and `clkRunning` stays high up to and including the first `cardEn` pulse in a cycle after the write cycle. `clkRunning` is low from the following cycle.
- R7: While `clkRunning` is low, `cardEn` is low, whatever `fastTick` does.
- R8: A start while running keeps `clkRunning` high, cancels a pending stop and restarts the period count from cycle 0 with the new code, as in R2.
- R9: A stop while stopped has no effect: `clkRunning` and `clkOffEvt` stay low.
- R10: `clkOffEvt` is high for exactly the first cycle in which `clkRunning` reads low after having been high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| rateWrite | input | 1 | Strobe: store `rateCode` as the pending rate |
| rateCode | input | RATE_W (3) | Log2 divide code; all-ones selects the fast tick |
| ctlWrite | input | 1 | Strobe: apply `ctlCmd` |
| ctlCmd | input | 2 | 2'b01 stop, 2'b10 or 2'b11 start, 2'b00 nothing |
| fastTick | input | 1 | Enable pulses from the fixed fast clock source |
| cardEn | output | 1 | One-cycle card clock enable |
| clkRunning | output | 1 | Card clock running status |
| clkOffEvt | output | 1 | One-cycle pulse when the clock has stopped |

## Verification
The bench sweeps every divide code. At each code it places the stop request at a different phase of the period, then checks exactly which pulse is the last one and the cycle where status and the off event change. A design that closed the gate mid-period would drop `clkRunning` early; one that ignored the pending stop would never raise `clkOffEvt`. A rate write during a run, followed by a start while a stop is pending, catches a design that applies the code too early, fails to reload the phase, or lets the stale stop win. Fast mode is driven with an irregular tick pattern, both running and after the stop, to catch leakage of the tick through a closed gate.

// File: rtl/card_clk_pkg.sv
package card_clk_pkg;
  localparam logic [1:0] CMD_STOP      = 2'b01;
  localparam int         CMD_START_BIT = 1;

  typedef struct packed {
    logic run;     // gate open
    logic reload;  // restart divider phase
  } gate_ctl_t;
endpackage

// File: rtl/card_clk_ctrl.sv
module card_clk_ctrl
  import card_clk_pkg::*;
#(
  parameter int RATE_W = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              rateWrite,
  input  logic [RATE_W-1:0] rateCode,
  input  logic              ctlWrite,
  input  logic [1:0]        ctlCmd,
  input  logic              tick,
  output gate_ctl_t         gate,
  output logic [RATE_W-1:0] activeCode,
  output logic              clkRunning,
  output logic              clkOffEvt
);
  logic [RATE_W-1:0] pendCode;
  logic [RATE_W-1:0] nextCode;
  logic              running;
  logic              stopPend;
  logic              startReq;
  logic              stopReq;

  assign startReq = ctlWrite && ctlCmd[CMD_START_BIT];
  assign stopReq  = ctlWrite && (ctlCmd == CMD_STOP);
  assign nextCode = rateWrite ? rateCode : pendCode;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pendCode   <= '0;
      activeCode <= '0;
      running    <= 1'b0;
      stopPend   <= 1'b0;
      clkOffEvt  <= 1'b0;
    end else begin
      pendCode  <= nextCode;
      clkOffEvt <= 1'b0;
      if (startReq) begin
        running    <= 1'b1;
        stopPend   <= 1'b0;
        activeCode <= nextCode;
      end else if (running && stopPend && tick) begin
        running   <= 1'b0;
        stopPend  <= 1'b0;
        clkOffEvt <= 1'b1;
      end else if (stopReq && running) begin
        stopPend <= 1'b1;
      end
    end
  end

  assign gate.run    = running;
  assign gate.reload = startReq;
  assign clkRunning  = running;
endmodule

// File: rtl/card_clk_div.sv
module card_clk_div
  import card_clk_pkg::*;
#(
  parameter int RATE_W = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  gate_ctl_t         gate,
  input  logic [RATE_W-1:0] activeCode,
  input  logic              fastTick,
  output logic              tick
);
  localparam int FAST_CODE = (1 << RATE_W) - 1;
  localparam int CNT_W     = FAST_CODE - 1;

  logic [CNT_W-1:0] maskTab [FAST_CODE+1];
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] curMask;
  logic             isFast;
  logic             wrap;

  for (genvar g = 0; g <= FAST_CODE; g++) begin : g_mask
    if (g == FAST_CODE) begin : g_fast
      assign maskTab[g] = '1;
    end else begin : g_div
      assign maskTab[g] = CNT_W'((64'd1 << g) - 64'd1);
    end
  end

  assign curMask = maskTab[activeCode];
  assign isFast  = (activeCode == RATE_W'(FAST_CODE));
  assign wrap    = (cnt == curMask);

  always_ff @(posedge clk) begin
    if (!rstN || gate.reload) begin
      cnt <= '0;
    end else if (gate.run) begin
      cnt <= wrap ? '0 : cnt + 1'b1;
    end
  end

  assign tick = gate.run && (isFast ? fastTick : wrap);
endmodule

// File: rtl/card_clk_gen.sv
module card_clk_gen
  import card_clk_pkg::*;
#(
  parameter int RATE_W = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              rateWrite,
  input  logic [RATE_W-1:0] rateCode,
  input  logic              ctlWrite,
  input  logic [1:0]        ctlCmd,
  input  logic              fastTick,
  output logic              cardEn,
  output logic              clkRunning,
  output logic              clkOffEvt
);
  gate_ctl_t         gate;
  logic [RATE_W-1:0] activeCode;
  logic              tick;

  card_clk_ctrl #(.RATE_W(RATE_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .rateWrite(rateWrite), .rateCode(rateCode),
    .ctlWrite(ctlWrite), .ctlCmd(ctlCmd), .tick(tick), .gate(gate),
    .activeCode(activeCode), .clkRunning(clkRunning), .clkOffEvt(clkOffEvt)
  );

  card_clk_div #(.RATE_W(RATE_W)) u_div (
    .clk(clk), .rstN(rstN), .gate(gate), .activeCode(activeCode),
    .fastTick(fastTick), .tick(tick)
  );

  assign cardEn = tick;
endmodule

// File: rtl/card_clk_chk.sv
module card_clk_chk #(
  parameter int RATE_W = 3
) (
  input logic              clk,
  input logic              rstN,
  input logic              rateWrite,
  input logic [RATE_W-1:0] rateCode,
  input logic              ctlWrite,
  input logic [1:0]        ctlCmd,
  input logic              fastTick,
  input logic              cardEn,
  input logic              clkRunning,
  input logic              clkOffEvt
);
  AST_NO_EN_WHEN_OFF: assert property (@(posedge clk) disable iff (!rstN)
    !clkRunning |-> !cardEn); // R7
  AST_STOP_AT_PERIOD_END: assert property (@(posedge clk) disable iff (!rstN)
    $fell(clkRunning) |-> $past(cardEn)); // R6
  AST_OFF_EVT_ON_FALL: assert property (@(posedge clk) disable iff (!rstN)
    $fell(clkRunning) |-> clkOffEvt); // R10
  AST_OFF_EVT_ONLY_FALL: assert property (@(posedge clk) disable iff (!rstN)
    clkOffEvt |-> $fell(clkRunning)); // R10
  AST_START_RUNS: assert property (@(posedge clk) disable iff (!rstN)
    (ctlWrite && ctlCmd[1]) |=> clkRunning); // R5
  AST_RISE_NEEDS_START: assert property (@(posedge clk) disable iff (!rstN)
    $rose(clkRunning) |-> $past(ctlWrite && ctlCmd[1])); // R5
  AST_STOP_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    (ctlWrite && ctlCmd == 2'b01 && !clkRunning) |=> (!clkRunning && !clkOffEvt)); // R9
endmodule

bind card_clk_gen card_clk_chk #(.RATE_W(RATE_W)) u_chk (
  .clk(clk), .rstN(rstN), .rateWrite(rateWrite), .rateCode(rateCode),
  .ctlWrite(ctlWrite), .ctlCmd(ctlCmd), .fastTick(fastTick),
  .cardEn(cardEn), .clkRunning(clkRunning), .clkOffEvt(clkOffEvt)
);

// File: tb/tb_card_clk_gen.sv
module tb_card_clk_gen;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       rateWrite = 1'b0;
  logic [2:0] rateCode = '0;
  logic       ctlWrite = 1'b0;
  logic [1:0] ctlCmd = '0;
  logic       fastTick = 1'b0;
  logic       cardEn, clkRunning, clkOffEvt;
  int checks = 0;
  int errors = 0;

  card_clk_gen #(.RATE_W(3)) dut (
    .clk(clk), .rstN(rstN), .rateWrite(rateWrite), .rateCode(rateCode),
    .ctlWrite(ctlWrite), .ctlCmd(ctlCmd), .fastTick(fastTick),
    .cardEn(cardEn), .clkRunning(clkRunning), .clkOffEvt(clkOffEvt)
  );

  always #2 clk = ~clk;

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d t=%0t", req, what, act, exp, $time);
    end
  endtask

  task automatic idle();
    rateWrite = 1'b0; ctlWrite = 1'b0; ctlCmd = 2'b00;
  endtask

  // start at code c, stop at a phase inside the third period, watch it close
  task automatic runSweep(input int c, input bit doRate, input string req);
    int p = 1 << c;
    int k0 = 2 * p + ((p > 2) ? 1 : 0);
    int kLast = ((k0 + 1) / p + 1) * p - 1;
    @(negedge clk);
    rateWrite = doRate; rateCode = 3'(c); ctlWrite = 1'b1; ctlCmd = 2'b10;
    @(negedge clk); idle();
    for (int k = 0; k <= kLast + 3; k++) begin
      chk(req, "cardEn", int'(cardEn), int'(k <= kLast && ((k + 1) % p) == 0));
      chk("R6", "clkRunning", int'(clkRunning), int'(k <= kLast));
      chk("R10", "clkOffEvt", int'(clkOffEvt), int'(k == kLast + 1));
      if (k == k0) begin ctlWrite = 1'b1; ctlCmd = 2'b01; end
      @(negedge clk); idle();
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    // R1: reset state
    repeat (3) @(negedge clk);
    chk("R1", "clkRunning", int'(clkRunning), 0);
    chk("R1", "cardEn", int'(cardEn), 0);
    chk("R1", "clkOffEvt", int'(clkOffEvt), 0);
    rstN = 1'b1;
    @(negedge clk);
    chk("R1", "clkRunning idle", int'(clkRunning), 0);
    // R1: default code 0 -> enable every cycle
    runSweep(0, 1'b0, "R1");
    // R2, R5: every divide code with the rate written alongside the start
    for (int c = 0; c < 7; c++) runSweep(c, 1'b1, "R2");

    // R9: stop while stopped
    @(negedge clk); ctlWrite = 1'b1; ctlCmd = 2'b01;
    @(negedge clk); idle();
    for (int k = 0; k < 5; k++) begin
      chk("R9", "clkRunning", int'(clkRunning), 0);
      chk("R9", "clkOffEvt", int'(clkOffEvt), 0);
      chk("R7", "cardEn", int'(cardEn), 0);
      @(negedge clk);
    end

    // R4, R8: rate write while running, then restart with a stop pending
    rateWrite = 1'b1; rateCode = 3'd2; ctlWrite = 1'b1; ctlCmd = 2'b10;
    @(negedge clk); idle();
    for (int k = 0; k <= 14; k++) begin
      chk("R4", "cardEn", int'(cardEn), int'(((k + 1) % 4) == 0));
      chk("R4", "clkRunning", int'(clkRunning), 1);
      if (k == 5) begin rateWrite = 1'b1; rateCode = 3'd5; end
      if (k == 13) begin ctlWrite = 1'b1; ctlCmd = 2'b01; end
      if (k == 14) begin ctlWrite = 1'b1; ctlCmd = 2'b11; end
      @(negedge clk); idle();
    end
    for (int j = 0; j <= 40; j++) begin
      chk("R8", "cardEn", int'(cardEn), int'(j == 31));
      chk("R8", "clkRunning", int'(clkRunning), 1);
      chk("R8", "clkOffEvt", int'(clkOffEvt), 0);
      @(negedge clk);
    end
    ctlWrite = 1'b1; ctlCmd = 2'b01;
    @(negedge clk); idle();
    repeat (30) @(negedge clk);
    chk("R6", "stopped after code 5", int'(clkRunning), 0);

    // R3: fast mode follows fastTick, then stop on a tick
    rateWrite = 1'b1; rateCode = 3'd7; ctlWrite = 1'b1; ctlCmd = 2'b10;
    @(negedge clk); idle();
    for (int k = 0; k <= 27; k++) begin
      idle();
      fastTick = (k < 21) ? ((k % 3) == 1) : (k == 23 || k >= 25);
      if (k == 20) begin ctlWrite = 1'b1; ctlCmd = 2'b01; end
      #1;
      chk(k <= 23 ? "R3" : "R7", "cardEn", int'(cardEn), int'(k <= 23 && fastTick));
      chk("R6", "clkRunning fast", int'(clkRunning), int'(k <= 23));
      chk("R10", "clkOffEvt fast", int'(clkOffEvt), int'(k == 24));
      @(negedge clk);
    end
    idle(); fastTick = 1'b0;

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule